// File: doc/BRIEF.md
# CPU Run Control and Instruction Stepping Unit

This block holds the run state of a pipelined processor as a debugger sees it. A debug host writes a small set of registers to halt the core, resume it, or let it retire a set number of instructions before it stops by itself. The core reports two events: a pulse for each retired instruction and a pulse when it decodes a software breakpoint instruction. The block answers with a pipeline halt level and a breakpoint-exception request.

One control bit decides how a breakpoint instruction is handled. When the bit is set, the instruction becomes an exception for the core's trap logic. When it is clear, the pipeline stops and a sticky flag records why. Two free-running counters support cycles-per-instruction measurement. The first counts clock cycles, but only while the core runs. The second counts retired instructions. Software can load either counter.

A soft-reset input returns the run state to "running, not stepping, no breakpoint". It leaves both measurement counters as they are, so a measurement can span a restart of the software.

Top module: `cpu_run_ctl`

## Requirements
- R1: Writes are qualified by `wr_en` and steered by `wr_sel`: 0 selects the status/control register, 1 the step count, 2 the cycle counter, 3 the retired counter and 4 the break control register. Codes 5 to 7 change nothing.
- R2: `status_o` carries the halt state in bit 0 and the breakpoint flag in bit 2. Bits 15:4 hold the `CORE_ID` parameter. Bit 1 (the stepping request) always reads 0, and every other bit reads 0.
- R3: Writing the status register with bit 0 set drives `halt_o` high from the next cycle. Writing it with bit 0 clear drives `halt_o` low from the next cycle and clears the breakpoint flag.
- R4: The core enters stepping when a status write has bit 1 set and the step count is non-zero. Each retire pulse while stepping and not halted lowers `steps_left_o` by one. The retire that brings the count to zero raises `halt_o` on the same clock edge and ends stepping.
- R5: A stepping request made while the step count is zero has no effect. The core runs freely, and retire pulses neither halt it nor change the count.
- R6: The cycle counter rises by one on every clock edge while `halt_o` is low and holds its value while `halt_o` is high.
- R7: The retired counter rises by one for every cycle in which `retire_i` is high.
- R8: A write to either counter loads the written value on the next edge, and counting resumes from that value.
- R9: When break control bit 0 is set, `ebreak_i` drives `brk_trap_o` high in the same cycle and neither halts the core nor sets the breakpoint flag.
- R10: When break control bit 0 is clear, `ebreak_i` raises `halt_o` and the breakpoint flag from the next cycle and ends any stepping.
- R11: `soft_rst` clears halt, stepping, the step count and the breakpoint flag on the next edge, and both counters keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous run-state reset; counters kept |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 64 | Write data |
| retire_i | input | 1 | One instruction retired this cycle |
| ebreak_i | input | 1 | Breakpoint instruction detected this cycle |
| halt_o | output | 1 | Pipeline halt level |
| brk_trap_o | output | 1 | Request a breakpoint exception |
| status_o | output | 64 | Status register read value |
| steps_left_o | output | 64 | Remaining step count |
| cycle_cnt_o | output | 64 | Cycle counter (frozen while halted) |
| retired_cnt_o | output | 64 | Retired-instruction counter |

## Verification
Several properties are checked on every cycle:
- a breakpoint flag never stands without halt;
- the final retire of a step run always halts;
- a non-trapping breakpoint halts and flags;
- a trapping one leaves the flag untouched;
- soft reset clears the run state;
- each counter either increments, holds or loads exactly as its enables dictate.

Some behaviours can only be shown by the bench's scenarios. These are:
- the exact step count reached across a sweep of run lengths;
- the zero-count stepping request that must do nothing;
- the status bit layout with a non-zero core ID;
- the cycle counter's value across halt and resume;
- the fact that unused select codes and soft reset leave the counters intact.

// File: rtl/cpu_run_ctl_pkg.sv
package cpu_run_ctl_pkg;

  parameter int XLEN = 64;
  parameter int ID_W = 12;

  typedef enum logic [2:0] {
    SEL_STATUS  = 3'd0,
    SEL_STEPS   = 3'd1,
    SEL_CYCLES  = 3'd2,
    SEL_RETIRED = 3'd3,
    SEL_BRKCTL  = 3'd4
  } wsel_e;

  localparam int ST_HALT_BIT = 0;
  localparam int ST_STEP_BIT = 1;
  localparam int ST_FLAG_BIT = 2;
  localparam int ST_ID_LSB   = 4;

  function automatic logic [XLEN-1:0] f_dec(input logic [XLEN-1:0] v);
    return v - XLEN'(1);
  endfunction

  function automatic logic [XLEN-1:0] f_inc(input logic [XLEN-1:0] v);
    return v + XLEN'(1);
  endfunction

  function automatic logic f_last_step(input logic [XLEN-1:0] v);
    return v == XLEN'(1);
  endfunction

  function automatic logic [XLEN-1:0] f_pack_status(input logic halt,
                                                   input logic flag,
                                                   input logic [ID_W-1:0] id);
    logic [XLEN-1:0] s;
    s = '0;
    s[ST_HALT_BIT] = halt;
    s[ST_FLAG_BIT] = flag;
    s[ST_ID_LSB +: ID_W] = id;
    return s;
  endfunction

endpackage

// File: rtl/run_perf_cnt.sv
module run_perf_cnt
  import cpu_run_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  input  logic            ld,
  input  logic [XLEN-1:0] ld_val,
  output logic [XLEN-1:0] cnt
);

  logic [XLEN-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (ld)  cnt_q <= ld_val;
    else if (inc) cnt_q <= f_inc(cnt_q);
  end

  assign cnt = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !ld |=> cnt == $past(cnt) + XLEN'(1)); // R7
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc && !ld |=> $stable(cnt)); // R6
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(ld_val)); // R8

endmodule

// File: rtl/run_step_ctl.sv
module run_step_ctl
  import cpu_run_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            wr_status,
  input  logic            wr_steps,
  input  logic            wr_brkctl,
  input  logic [XLEN-1:0] wr_data,
  input  logic            retire_i,
  input  logic            ebreak_i,
  output logic            halt_q,
  output logic            stepping_q,
  output logic            flag_q,
  output logic [XLEN-1:0] steps_q,
  output logic            brk_trap
);

  logic trap_en_q;
  logic step_tick;
  logic step_hit;
  logic ebreak_halt;

  assign step_tick   = stepping_q && !halt_q && retire_i && !wr_status;
  assign step_hit    = step_tick && f_last_step(steps_q);
  assign ebreak_halt = ebreak_i && !trap_en_q;
  assign brk_trap    = ebreak_i && trap_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q     <= 1'b0;
      stepping_q <= 1'b0;
      flag_q     <= 1'b0;
      steps_q    <= '0;
      trap_en_q  <= 1'b0;
    end else if (soft_rst) begin
      halt_q     <= 1'b0;
      stepping_q <= 1'b0;
      flag_q     <= 1'b0;
      steps_q    <= '0;
    end else begin
      if (wr_status) begin
        halt_q     <= wr_data[ST_HALT_BIT];
        stepping_q <= wr_data[ST_STEP_BIT] && (steps_q != '0);
        if (!wr_data[ST_HALT_BIT]) flag_q <= 1'b0;
      end else if (ebreak_halt) begin
        halt_q     <= 1'b1;
        flag_q     <= 1'b1;
        stepping_q <= 1'b0;
      end else if (step_hit) begin
        halt_q     <= 1'b1;
        stepping_q <= 1'b0;
      end
      if (wr_steps)       steps_q <= wr_data;
      else if (step_tick) steps_q <= f_dec(steps_q);
      if (wr_brkctl) trap_en_q <= wr_data[0];
    end
  end

  AST_FLAG_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |-> halt_q); // R3
  AST_LAST_STEP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    stepping_q && !halt_q && retire_i && steps_q == XLEN'(1) && !soft_rst && !wr_status
    |=> halt_q && !stepping_q); // R4
  AST_EBREAK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ebreak_i && !brk_trap && !soft_rst && !wr_status |=> halt_q && flag_q); // R10
  AST_TRAP_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    brk_trap && !soft_rst && !wr_status |=> $stable(flag_q)); // R9
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !halt_q && !stepping_q && !flag_q && steps_q == '0); // R11
  AST_NO_EMPTY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    stepping_q |-> steps_q != '0); // R5

endmodule

// File: rtl/cpu_run_ctl.sv
module cpu_run_ctl
  import cpu_run_ctl_pkg::*;
#(
  parameter logic [ID_W-1:0] CORE_ID = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic            retire_i,
  input  logic            ebreak_i,
  output logic            halt_o,
  output logic            brk_trap_o,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] steps_left_o,
  output logic [XLEN-1:0] cycle_cnt_o,
  output logic [XLEN-1:0] retired_cnt_o
);

  wsel_e sel;
  logic  wr_status, wr_steps, wr_cycles, wr_retired, wr_brkctl;
  logic  halt_q, stepping_q, flag_q;

  assign sel        = wsel_e'(wr_sel);
  assign wr_status  = wr_en && (sel == SEL_STATUS);
  assign wr_steps   = wr_en && (sel == SEL_STEPS);
  assign wr_cycles  = wr_en && (sel == SEL_CYCLES);
  assign wr_retired = wr_en && (sel == SEL_RETIRED);
  assign wr_brkctl  = wr_en && (sel == SEL_BRKCTL);

  run_step_ctl u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .wr_status  (wr_status),
    .wr_steps   (wr_steps),
    .wr_brkctl  (wr_brkctl),
    .wr_data    (wr_data),
    .retire_i   (retire_i),
    .ebreak_i   (ebreak_i),
    .halt_q     (halt_q),
    .stepping_q (stepping_q),
    .flag_q     (flag_q),
    .steps_q    (steps_left_o),
    .brk_trap   (brk_trap_o)
  );

  run_perf_cnt u_cycles (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (!halt_q),
    .ld     (wr_cycles),
    .ld_val (wr_data),
    .cnt    (cycle_cnt_o)
  );

  run_perf_cnt u_retired (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (retire_i),
    .ld     (wr_retired),
    .ld_val (wr_data),
    .cnt    (retired_cnt_o)
  );

  assign halt_o   = halt_q;
  assign status_o = f_pack_status(halt_q, flag_q, CORE_ID);

  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o && !wr_cycles |=> $stable(cycle_cnt_o)); // R6
  AST_STEP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[ST_STEP_BIT] == 1'b0 && status_o[3] == 1'b0); // R2
  AST_SOFT_KEEPS_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && !retire_i && !wr_retired |=> $stable(retired_cnt_o)); // R11

endmodule

// File: tb/cpu_run_ctl_bench.sv
module cpu_run_ctl_bench;

  localparam logic [11:0] ID = 12'h5A3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic        retire_i = 1'b0;
  logic        ebreak_i = 1'b0;
  logic        halt_o, brk_trap_o;
  logic [63:0] status_o, steps_left_o, cycle_cnt_o, retired_cnt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cpu_run_ctl #(.CORE_ID(ID)) u_cpu_run_ctl (
    .clk, .rst_n, .soft_rst, .wr_en, .wr_sel, .wr_data, .retire_i, .ebreak_i,
    .halt_o, .brk_trap_o, .status_o, .steps_left_o, .cycle_cnt_o, .retired_cnt_o
  );

  function automatic logic [63:0] exp_status(input logic h, input logic f);
    return (64'(ID) << 4) | (64'(f) << 2) | 64'(h);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [63:0] d);
    wr_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic retire(input int n);
    for (int i = 0; i < n; i++) begin
      retire_i = 1'b1;
      @(negedge clk);
      retire_i = 1'b0;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [63:0] c0, r0;
    repeat (3) @(negedge clk);
    chk("R1 reset cycles", cycle_cnt_o, 64'd0);
    rst_n = 1'b1;
    chk("R1 reset halt", 64'(halt_o), 64'd0);
    chk("R2 reset status", status_o, exp_status(0, 0));
    chk("R1 reset retired", retired_cnt_o, 64'd0);
    chk("R1 reset steps", steps_left_o, 64'd0);

    // R3 halt and resume; R6 freeze while halted
    wr(3'd0, 64'h1);
    chk("R3 halt set", 64'(halt_o), 64'd1);
    c0 = cycle_cnt_o;
    repeat (5) @(negedge clk);
    chk("R6 frozen", cycle_cnt_o, c0);
    wr(3'd0, 64'h0);
    chk("R3 resume", 64'(halt_o), 64'd0);
    c0 = cycle_cnt_o;
    repeat (7) @(negedge clk);
    chk("R6 running", cycle_cnt_o, c0 + 64'd7);

    // R8 counter loads
    wr(3'd2, 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R8 cycle load", cycle_cnt_o, 64'hFFFF_FFFF_FFFF_FFFE);
    repeat (3) @(negedge clk);
    chk("R8 cycle wraps on", cycle_cnt_o, 64'd1);
    wr(3'd3, 64'd100);
    chk("R8 retired load", retired_cnt_o, 64'd100);
    retire(9);
    chk("R7 retired count", retired_cnt_o, 64'd109);

    // R1 unused select codes
    for (int s = 5; s < 8; s++) begin
      r0 = retired_cnt_o;
      wr(3'(s), 64'hF);
      chk("R1 unused code halt", 64'(halt_o), 64'd0);
      chk("R1 unused code steps", steps_left_o, 64'd0);
      chk("R1 unused code retired", retired_cnt_o, r0);
    end

    // R4 sweep of step counts
    for (int n = 1; n <= 6; n++) begin
      wr(3'd0, 64'h1);
      wr(3'd1, 64'(n));
      r0 = retired_cnt_o;
      wr(3'd0, 64'h2);
      chk("R4 step start", 64'(halt_o), 64'd0);
      chk("R2 step bit reads 0", status_o, exp_status(0, 0));
      for (int i = 1; i <= n; i++) begin
        retire(1);
        chk("R4 step halt", 64'(halt_o), 64'(i == n));
        chk("R4 step left", steps_left_o, 64'(n - i));
      end
      retire(2);
      chk("R4 stays halted", 64'(halt_o), 64'd1);
      chk("R7 retired during steps", retired_cnt_o, r0 + 64'(n + 2));
    end

    // R5 zero-count stepping request
    wr(3'd0, 64'h2);
    retire(10);
    chk("R5 no halt", 64'(halt_o), 64'd0);
    chk("R5 count unchanged", steps_left_o, 64'd0);

    // R9 trapping breakpoint
    wr(3'd4, 64'h1);
    ebreak_i = 1'b1;
    #1;
    chk("R9 trap raised", 64'(brk_trap_o), 64'd1);
    @(negedge clk);
    ebreak_i = 1'b0;
    chk("R9 no halt", 64'(halt_o), 64'd0);
    chk("R9 no flag", status_o, exp_status(0, 0));

    // R10 halting breakpoint, ends stepping
    wr(3'd4, 64'h0);
    wr(3'd1, 64'd10);
    wr(3'd0, 64'h2);
    retire(2);
    ebreak_i = 1'b1;
    #1;
    chk("R10 no trap", 64'(brk_trap_o), 64'd0);
    @(negedge clk);
    ebreak_i = 1'b0;
    chk("R10 halted flagged", status_o, exp_status(1, 1));
    chk("R10 steps kept", steps_left_o, 64'd8);
    wr(3'd0, 64'h1);
    chk("R3 flag kept while halt", status_o, exp_status(1, 1));
    wr(3'd0, 64'h0);
    chk("R3 flag cleared on resume", status_o, exp_status(0, 0));
    retire(9);
    chk("R10 stepping ended", 64'(halt_o), 64'd0);

    // R11 soft reset
    wr(3'd1, 64'd5);
    wr(3'd0, 64'h2);
    retire(1);
    ebreak_i = 1'b1;
    @(negedge clk);
    ebreak_i = 1'b0;
    r0 = retired_cnt_o;
    c0 = cycle_cnt_o;
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R11 status", status_o, exp_status(0, 0));
    chk("R11 steps", steps_left_o, 64'd0);
    chk("R11 retired kept", retired_cnt_o, r0);
    chk("R11 cycles kept", cycle_cnt_o, c0);
    retire(6);
    chk("R11 stepping gone", 64'(halt_o), 64'd0);

    finish_run();
  end

endmodule